// File: doc/BRIEF.md
# Filtered Edge Input Capture

This block watches an asynchronous capture pin and, on an edge of the selected polarity, copies the value of an external free-running counter into a holding register. The pin is first brought into the clock domain by a synchronizer chain. An optional level filter can be switched into the path. When the filter is on, an edge counts only after the synchronized pin has held the target level for a number of consecutive clock samples. The filter works at the full clock rate and does not depend on any timer prescaler.

Each accepted edge produces three results. The captured count appears on `cap_value`. A one-cycle pulse appears on `cap_strobe`. A sticky `cap_flag` is set, and software clears it through a write-one-to-clear pulse. A separate enable blocks all captures, so the pin can serve as plain I/O without disturbing the holding register. The counter itself, bus access and interrupt routing sit outside this block.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, `cap_value` is 0, `cap_strobe` is 0 and `cap_flag` is 0. All control inputs are expected to be 0 at that time, which means capture is disabled, the filter is off and the falling edge is selected.
- R2: While `cap_en` is 0, no pin activity changes `cap_value`, pulses `cap_strobe` or sets `cap_flag`.
- R3: With `edge_rise` = 0, only a high-to-low transition of the pin causes a capture. With `edge_rise` = 1, only a low-to-high transition does. A transition of the other direction is ignored.
- R4: With the filter off (`filt_en` = 0), a pin transition applied just after clock edge N produces `cap_strobe` high after clock edge N+3 (two synchronizer flops plus the capture register). The new `cap_value` appears together with the strobe and equals the `cnt_val` presented between edges N+2 and N+3.
- R5: With `filt_en` = 1, a capture needs four consecutive synchronized samples at the target level (high for rising, low for falling). A transition that then holds produces `cap_strobe` after edge N+6, and `cap_value` equals the `cnt_val` presented between edges N+5 and N+6.
- R6: With `filt_en` = 1, a pulse toward the target level that lasts three clock cycles or less produces no capture.
- R7: `cap_strobe` is high for exactly one cycle per accepted edge.
- R8: `cap_flag` is set with every capture and stays set until `flag_clr` is sampled high, after which it reads 0 on the next cycle. If `flag_clr` is high in the same cycle that a capture is taken, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the filter sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Raw asynchronous capture pin |
| cnt_val | input | 16 | Current value of the free-running counter |
| cap_en | input | 1 | Capture enable, 1 allows captures |
| edge_rise | input | 1 | Edge polarity: 0 falling, 1 rising |
| filt_en | input | 1 | 1 inserts the four-sample level filter |
| flag_clr | input | 1 | Write-one-to-clear pulse for the sticky flag |
| cap_value | output | 16 | Last captured counter value |
| cap_strobe | output | 1 | One-cycle capture pulse |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The bench runs the counter input through a new value on every cycle. Because of that, a capture taken one cycle early or late shows up as a wrong value and also as a wrong strobe cycle; a design that miscounted synchronizer or filter stages would be caught both ways. Pin transitions of the direction that was not selected are applied in both polarities, so a detector that is blind to polarity would produce strobes the bench never expected. Three-cycle glitches are sent through the filter in both directions. A filter that was one sample short, or that captured on a partial run, would fire on them. The bench also raises a clear in the same cycle that a capture is recognised, which exposes a flag that gives priority to the clear.

// File: rtl/cap_pkg.sv
// Package: shared constants and types for the edge capture block.
// Assumes: nothing beyond IEEE 1800-2017.
package cap_pkg;

    // Edge polarity encoding as seen on the edge_rise input.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;

    // Default geometry of the block.
    localparam int unsigned CAP_CNT_W       = 16;
    localparam int unsigned CAP_SYNC_STAGES = 2;
    localparam int unsigned CAP_FILT_LEN    = 4;

endpackage

// File: rtl/cap_sync.sv
// Module: cap_sync
// Brings an asynchronous level into the clk domain through a flop chain.
// Assumes: STAGES >= 2; the input may change at any time relative to clk.
module cap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the synchronizer flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/cap_edge_qual.sv
// Module: cap_edge_qual
// Turns a synchronized level into a one-cycle "qualified edge" indication.
// The indication is either the raw edge or the edge of a filtered level,
// where the filtered level only moves after FILT_LEN equal samples.
// Assumes: lvl is already synchronous to clk; FILT_LEN >= 2.
module cap_edge_qual
    import cap_pkg::*;
#(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    input  logic filt_en,
    output logic hit
);
    localparam int unsigned HIST_W = FILT_LEN - 1;

    logic              lvl_prev;
    logic [HIST_W-1:0] hist;
    logic              flt_lvl;
    logic              all_hi;
    logic              all_lo;
    logic              raw_rise;
    logic              raw_fall;
    logic              flt_rise;
    logic              flt_fall;
    edge_pol_e         pol;

    assign pol = edge_pol_e'(rise_sel);

    // Remember the previous synchronized level for raw edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev <= 1'b0;
        end else begin
            lvl_prev <= lvl;
        end
    end

    // Keep a history of the last HIST_W samples for the filter.
    generate
        if (HIST_W > 1) begin : g_hist_wide
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist <= '0;
                end else begin
                    hist <= {hist[HIST_W-2:0], lvl};
                end
            end
        end else begin : g_hist_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist <= '0;
                end else begin
                    hist <= lvl;
                end
            end
        end
    endgenerate

    // Run detection for a full window of equal samples.
    always_comb begin
        all_hi = lvl & (&hist);
        all_lo = ~lvl & ~(|hist);
    end

    // The filtered level moves only when a full run has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_lvl <= 1'b0;
        end else if (all_hi) begin
            flt_lvl <= 1'b1;
        end else if (all_lo) begin
            flt_lvl <= 1'b0;
        end
    end

    // Form the candidate edges and pick one by filter and polarity.
    always_comb begin
        raw_rise = lvl & ~lvl_prev;
        raw_fall = ~lvl & lvl_prev;
        flt_rise = all_hi & ~flt_lvl;
        flt_fall = all_lo & flt_lvl;
        if (filt_en) begin
            hit = (pol == EDGE_RISE) ? flt_rise : flt_fall;
        end else begin
            hit = (pol == EDGE_RISE) ? raw_rise : raw_fall;
        end
    end
endmodule

// File: rtl/cap_store.sv
// Module: cap_store
// Holds the captured counter value, the capture pulse and the sticky flag.
// Assumes: hit is a single-cycle indication synchronous to clk.
module cap_store #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             cap_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_strobe,
    output logic             cap_flag
);
    logic take;

    // A capture is taken only while captures are enabled.
    assign take = hit & cap_en;

    // Latch the counter on an accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_value <= '0;
        end else if (take) begin
            cap_value <= cnt_val;
        end
    end

    // Pulse the strobe for one cycle per capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_strobe <= 1'b0;
        end else begin
            cap_strobe <= take;
        end
    end

    // Sticky flag: a capture sets it and has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_flag <= 1'b0;
        end else if (take) begin
            cap_flag <= 1'b1;
        end else if (flag_clr) begin
            cap_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/edge_capture_unit.sv
// Module: edge_capture_unit (top)
// Synchronizes the capture pin, qualifies an edge (optionally filtered),
// and stores the counter value on each accepted edge.
// Assumes: control inputs are synchronous to clk; cnt_val is driven by an
// external free-running counter.
module edge_capture_unit
    import cap_pkg::*;
#(
    parameter int unsigned CNT_W       = CAP_CNT_W,
    parameter int unsigned SYNC_STAGES = CAP_SYNC_STAGES,
    parameter int unsigned FILT_LEN    = CAP_FILT_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cap_en,
    input  logic             edge_rise,
    input  logic             filt_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_strobe,
    output logic             cap_flag
);
    logic pin_sync;
    logic edge_hit;

    cap_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_pin),
        .dout  (pin_sync)
    );

    cap_edge_qual #(
        .FILT_LEN (FILT_LEN)
    ) i_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (pin_sync),
        .rise_sel (edge_rise),
        .filt_en  (filt_en),
        .hit      (edge_hit)
    );

    cap_store #(
        .CNT_W (CNT_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (edge_hit),
        .cap_en     (cap_en),
        .cnt_val    (cnt_val),
        .flag_clr   (flag_clr),
        .cap_value  (cap_value),
        .cap_strobe (cap_strobe),
        .cap_flag   (cap_flag)
    );
endmodule

// File: rtl/edge_capture_chk.sv
// Module: edge_capture_chk
// Property checker for edge_capture_unit, attached with bind below.
// Assumes: it sees only the top-level ports.
module edge_capture_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_en,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_strobe,
    input logic             cap_flag
);
    AST_NO_CAP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |-> $past(cap_en)); // R2

    AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_strobe |-> $stable(cap_value)); // R4

    AST_FLAG_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |-> cap_flag); // R8

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_clr) && !cap_strobe) |-> !cap_flag); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag); // R8
endmodule

bind edge_capture_unit edge_capture_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .flag_clr   (flag_clr),
    .cap_value  (cap_value),
    .cap_strobe (cap_strobe),
    .cap_flag   (cap_flag)
);

// File: tb/test_edge_capture_unit.sv
// Scoreboard bench for edge_capture_unit; clock period 4 time units (250 MHz).
module test_edge_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cap_en = 1'b0;
    logic        edge_rise = 1'b0;
    logic        filt_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_value;
    logic        cap_strobe;
    logic        cap_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit prev_strobe = 1'b0;

    typedef struct {
        int          at;
        logic [15:0] val;
        bit          filt;
    } exp_t;
    exp_t q[$];

    edge_capture_unit i_edge_capture_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_pin    (cap_pin),
        .cnt_val    (cnt_val),
        .cap_en     (cap_en),
        .edge_rise  (edge_rise),
        .filt_en    (filt_en),
        .flag_clr   (flag_clr),
        .cap_value  (cap_value),
        .cap_strobe (cap_strobe),
        .cap_flag   (cap_flag)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] cnt_of(int c);
        return 16'(c * 37 + 5);
    endfunction

    // Cycle counter and a counter input that changes every cycle.
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) cnt_val <= cnt_of(cyc);

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: change the pin and, when a capture is due, queue its expectation.
    task automatic drive_pin(logic v, bit expect_cap);
        @(negedge clk);
        cap_pin = v;
        if (expect_cap) begin
            exp_t e;
            int lat;
            lat = filt_en ? 6 : 3;
            e.at = cyc + lat;
            e.val = cnt_of(cyc + lat - 1);
            e.filt = filt_en;
            q.push_back(e);
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic pulse(logic v, int len);
        @(negedge clk);
        cap_pin = v;
        repeat (len) @(negedge clk);
        cap_pin = ~v;
        repeat (10) @(negedge clk);
    endtask

    // Monitor: compare each strobe with the scoreboard, report misses and R7 widths.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_strobe) check(!cap_strobe, "R7", "strobe width", cap_strobe, 0);
            if (cap_strobe) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2/R3/R6", "unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.at, e.filt ? "R5" : "R4", "strobe cycle", cyc, e.at);
                    check(cap_value == e.val, e.filt ? "R5" : "R4", "value", cap_value, e.val);
                end
            end else if (q.size() > 0 && cyc > q[0].at) begin
                check(1'b0, q[0].filt ? "R5" : "R4", "missing strobe", cyc, q[0].at);
                void'(q.pop_front());
            end
            prev_strobe <= cap_strobe;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cap_value == 0, "R1", "value", cap_value, 0);
        check(!cap_strobe, "R1", "strobe", cap_strobe, 0);
        check(!cap_flag, "R1", "flag", cap_flag, 0);

        // R3 and R4: falling edge selected, rising ignored
        cap_en = 1'b1;
        drive_pin(1'b1, 1'b0);
        drive_pin(1'b0, 1'b1);
        check(cap_flag, "R8", "flag set", cap_flag, 1);

        // R3: rising edge selected, falling ignored
        edge_rise = 1'b1;
        drive_pin(1'b1, 1'b1);
        drive_pin(1'b0, 1'b0);

        // R8: clear in the same cycle as a capture, capture wins
        @(negedge clk);
        cap_pin = 1'b1;
        begin
            exp_t e;
            e.at = cyc + 3; e.val = cnt_of(cyc + 2); e.filt = 1'b0;
            q.push_back(e);
        end
        repeat (2) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(cap_flag, "R8", "capture beats clear", cap_flag, 1);
        repeat (8) @(negedge clk);
        // R8: a plain clear
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(!cap_flag, "R8", "flag cleared", cap_flag, 0);
        drive_pin(1'b0, 1'b0);

        // R2: disabled, no captures in either direction
        cap_en = 1'b0;
        held = cap_value;
        drive_pin(1'b1, 1'b0);
        drive_pin(1'b0, 1'b0);
        check(cap_value == held, "R2", "value held", cap_value, held);
        check(!cap_flag, "R2", "flag untouched", cap_flag, 0);
        cap_en = 1'b1;

        // R5: filtered rising edge
        filt_en = 1'b1;
        drive_pin(1'b1, 1'b1);
        // R6: three-cycle low glitch while falling selected
        edge_rise = 1'b0;
        pulse(1'b0, 3);
        // R5: filtered falling edge
        drive_pin(1'b0, 1'b1);
        // R6: three-cycle high glitch while rising selected
        edge_rise = 1'b1;
        pulse(1'b1, 3);
        // R5: filtered rising edge once more
        drive_pin(1'b1, 1'b1);

        repeat (10) @(negedge clk);
        check(q.size() == 0, "R4/R5", "pending captures", q.size(), 0);
        finish_run();
    end
endmodule